// File: doc/BRIEF.md
# Grouped Vector Element Loop Sequencer

This block is the loop controller behind a scalar-issue vector extension. One vector instruction becomes a run of sub-operations. Each vector element is split into a group of one to four sub-elements. The block walks the element index in the outer loop and the sub-element index in the inner loop, and issues one sub-operation per clock. With each sub-operation it gives the element index, the sub-element index and an enable. The enable comes from one predicate bit per element, so a single mask bit turns a whole group on or off.

The loop geometry sits in a packed configuration register. It holds the maximum length, the active length, the start offsets for source and destination elements, the group size, and the start sub-element offsets for source and destination. A write port sets all of these in one cycle. On the way in it clamps every field into a legal range. A group size outside 1..4 raises a one-cycle exception flag and is not stored. A start pulse launches the walk, a stall input freezes it, and a done pulse marks its end. The operations themselves, the register files and the mask source are outside this block.

Top module: `sv_group_loop`

## Requirements
- R1: After reset, `cfg_state` reads all zeros: group size 1, length 1, maximum length 1, all offsets 0. `step_valid`, `done` and `grp_exc` are low.
- R2: `cfg_state` packs, from its top bit down, dst_sub[29:28], src_sub[27:26], group[25:24], dst_off[23:18], src_off[17:12], len[11:6], maxlen[5:0]. The group field holds the group size minus one (0b00..0b11 for 1..4).
- R3: A write with `cfg_grp` equal to 0 or above 4 keeps the stored group field. It raises `grp_exc` for exactly the one cycle after the write. The other fields are still written. A legal write leaves `grp_exc` low.
- R4: The written maximum length is clamped to 1..64 and stored as value minus one.
- R5: The written length is clamped to 1..maximum length (the clamped maximum from the same write) and stored as value minus one.
- R6: The element offsets are clamped to at most length minus one. The sub-element offsets are clamped to at most group size minus one, using the group size that is in force after the write.
- R7: After `start`, steps come out one per unstalled cycle. The first step is at element src_off and sub-element src_sub. The sub-element index counts up to group size minus one and wraps to 0, and only then does the element index advance. The last step is sub-element group-1 of element len-1.
- R8: `step_en` equals bit `step_elem` of `pred_mask` for every sub-element of that element. A clear bit suppresses the whole group, but its steps still take their cycles.
- R9: `done` is high for exactly one cycle: the cycle right after the last step. `step_valid` is low in that cycle.
- R10: While `stall` is high, `step_valid` is low and neither index moves. No step is lost or repeated.
- R11: While a walk is running, configuration writes are ignored (no state change, no `grp_exc`), and so is `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_maxlen | input | 7 | Requested maximum length (plain value) |
| cfg_len | input | 7 | Requested length (plain value) |
| cfg_src_off | input | 6 | Requested source element start offset |
| cfg_dst_off | input | 6 | Requested destination element start offset |
| cfg_grp | input | 3 | Requested group size, legal 1..4 |
| cfg_src_sub | input | 2 | Requested source sub-element start offset |
| cfg_dst_sub | input | 2 | Requested destination sub-element start offset |
| cfg_state | output | 30 | Packed stored configuration |
| grp_exc | output | 1 | Illegal group-size write flag |
| start | input | 1 | Launch a walk |
| stall | input | 1 | Freeze the walk |
| pred_mask | input | 64 | One predicate bit per element |
| step_valid | output | 1 | A sub-operation is issued this cycle |
| step_elem | output | 6 | Element index of the step |
| step_sub | output | 2 | Sub-element index of the step |
| step_en | output | 1 | Predicate enable of the step |
| done | output | 1 | Walk finished |

## Verification
The bench aims at the points where a walk can start or end wrong. A non-zero sub-element start offset must apply to the first element only; a design that reapplied it to every element would drop steps, and one that ignored it would add steps. A stall held across several edges must neither lose nor duplicate a step, and a write or start arriving mid-walk must not disturb the walk. Illegal group sizes 0 and 5 must keep the old group and pulse the flag for one cycle, not wedge it high. Over-range and zero writes must land on the clamped limits rather than wrap, and a cleared mask bit must suppress every sub-element of its element, not just the first.

// File: rtl/sv_grp_pkg.sv
package sv_grp_pkg;

    localparam int unsigned XLEN    = 64;
    localparam int unsigned MAX_GRP = 4;
    localparam int unsigned IDX_W   = $clog2(XLEN);
    localparam int unsigned SUB_W   = $clog2(MAX_GRP);
    localparam int unsigned GRP_W   = SUB_W + 1;
    localparam int unsigned LEN_W   = IDX_W + 1;

    // Most significant field first; the group field lands at 4*IDX_W.
    typedef struct packed {
        logic [SUB_W-1:0] dst_sub_off;
        logic [SUB_W-1:0] src_sub_off;
        logic [SUB_W-1:0] grp_enc;
        logic [IDX_W-1:0] dst_elem_off;
        logic [IDX_W-1:0] src_elem_off;
        logic [IDX_W-1:0] len_m1;
        logic [IDX_W-1:0] maxlen_m1;
    } loop_state_t;

    localparam int unsigned STATE_W = $bits(loop_state_t);
    localparam int unsigned GRP_LSB = 4 * IDX_W;

    // Clamp a plain length value into 1..hi.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v,
                                                   input logic [LEN_W-1:0] hi);
        if (v == '0)
            return LEN_W'(1);
        if (v > hi)
            return hi;
        return v;
    endfunction

    // Clamp an element offset to at most last.
    function automatic logic [IDX_W-1:0] clamp_idx(input logic [IDX_W-1:0] v,
                                                   input logic [IDX_W-1:0] last);
        return (v > last) ? last : v;
    endfunction

    // Clamp a sub-element offset to at most last.
    function automatic logic [SUB_W-1:0] clamp_sub(input logic [SUB_W-1:0] v,
                                                   input logic [SUB_W-1:0] last);
        return (v > last) ? last : v;
    endfunction

endpackage

// File: rtl/sv_grp_state.sv
module sv_grp_state
    import sv_grp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_maxlen,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [IDX_W-1:0] wr_src_off,
    input  logic [IDX_W-1:0] wr_dst_off,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [SUB_W-1:0] wr_src_sub,
    input  logic [SUB_W-1:0] wr_dst_sub,
    output loop_state_t      state_q,
    output logic             grp_exc
);

    logic             grp_ok;
    logic [SUB_W-1:0] grp_nx;
    logic [LEN_W-1:0] maxlen_v;
    logic [LEN_W-1:0] len_v;
    logic [IDX_W-1:0] last_idx;
    loop_state_t      state_nx;

    always_comb begin
        grp_ok   = (wr_grp != '0) && (wr_grp <= GRP_W'(MAX_GRP));
        grp_nx   = grp_ok ? SUB_W'(wr_grp - GRP_W'(1)) : state_q.grp_enc;
        maxlen_v = clamp_len(wr_maxlen, LEN_W'(XLEN));
        len_v    = clamp_len(wr_len, maxlen_v);
        last_idx = IDX_W'(len_v - LEN_W'(1));

        state_nx.maxlen_m1    = IDX_W'(maxlen_v - LEN_W'(1));
        state_nx.len_m1       = last_idx;
        state_nx.src_elem_off = clamp_idx(wr_src_off, last_idx);
        state_nx.dst_elem_off = clamp_idx(wr_dst_off, last_idx);
        state_nx.grp_enc      = grp_nx;
        state_nx.src_sub_off  = clamp_sub(wr_src_sub, grp_nx);
        state_nx.dst_sub_off  = clamp_sub(wr_dst_sub, grp_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            grp_exc <= 1'b0;
        end else begin
            grp_exc <= wr_en && !grp_ok;
            if (wr_en)
                state_q <= state_nx;
        end
    end

endmodule

// File: rtl/sv_grp_seq.sv
module sv_grp_seq
    import sv_grp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stall,
    input  loop_state_t      cfg,
    input  logic [XLEN-1:0]  pred_mask,
    output logic             busy,
    output logic             step_valid,
    output logic [IDX_W-1:0] step_elem,
    output logic [SUB_W-1:0] step_sub,
    output logic             step_en,
    output logic             done
);

    logic [IDX_W-1:0] elem_q;
    logic [SUB_W-1:0] sub_q;
    logic             sub_wrap;
    logic             last_elem;

    assign sub_wrap   = (sub_q == cfg.grp_enc);
    assign last_elem  = (elem_q == cfg.len_m1);
    assign step_valid = busy && !stall;
    assign step_elem  = elem_q;
    assign step_sub   = sub_q;
    assign step_en    = pred_mask[elem_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            elem_q <= '0;
            sub_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    elem_q <= cfg.src_elem_off;
                    sub_q  <= cfg.src_sub_off;
                end
            end else if (!stall) begin
                if (sub_wrap) begin
                    sub_q <= '0;
                    if (last_elem) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        elem_q <= elem_q + IDX_W'(1);
                    end
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sv_group_loop.sv
module sv_group_loop
    import sv_grp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [LEN_W-1:0]   cfg_maxlen,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [IDX_W-1:0]   cfg_src_off,
    input  logic [IDX_W-1:0]   cfg_dst_off,
    input  logic [GRP_W-1:0]   cfg_grp,
    input  logic [SUB_W-1:0]   cfg_src_sub,
    input  logic [SUB_W-1:0]   cfg_dst_sub,
    output logic [STATE_W-1:0] cfg_state,
    output logic               grp_exc,
    input  logic               start,
    input  logic               stall,
    input  logic [XLEN-1:0]    pred_mask,
    output logic               step_valid,
    output logic [IDX_W-1:0]   step_elem,
    output logic [SUB_W-1:0]   step_sub,
    output logic               step_en,
    output logic               done
);

    loop_state_t state;
    logic        seq_busy;
    logic        wr_accept;

    // The geometry is frozen while a walk is in flight.
    assign wr_accept = cfg_wr && !seq_busy;
    assign cfg_state = state;

    sv_grp_state u_state (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_accept),
        .wr_maxlen  (cfg_maxlen),
        .wr_len     (cfg_len),
        .wr_src_off (cfg_src_off),
        .wr_dst_off (cfg_dst_off),
        .wr_grp     (cfg_grp),
        .wr_src_sub (cfg_src_sub),
        .wr_dst_sub (cfg_dst_sub),
        .state_q    (state),
        .grp_exc    (grp_exc)
    );

    sv_grp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .stall      (stall),
        .cfg        (state),
        .pred_mask  (pred_mask),
        .busy       (seq_busy),
        .step_valid (step_valid),
        .step_elem  (step_elem),
        .step_sub   (step_sub),
        .step_en    (step_en),
        .done       (done)
    );

endmodule

// File: rtl/sv_group_loop_chk.sv
module sv_group_loop_chk
    import sv_grp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr,
    input logic [GRP_W-1:0]   cfg_grp,
    input logic [STATE_W-1:0] cfg_state,
    input logic               grp_exc,
    input logic               stall,
    input logic               step_valid,
    input logic [IDX_W-1:0]   step_elem,
    input logic [SUB_W-1:0]   step_sub,
    input logic               done,
    input logic               seq_busy
);

    loop_state_t st;
    logic        bad_grp;

    assign st      = cfg_state;
    assign bad_grp = (cfg_grp == '0) || (cfg_grp > GRP_W'(MAX_GRP));

    AST_BAD_GRP_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !seq_busy && bad_grp) |=> (st.grp_enc == $past(st.grp_enc))); // R3

    AST_BAD_GRP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !seq_busy && bad_grp) |=> grp_exc); // R3

    AST_FLAG_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && !seq_busy && bad_grp) |=> !grp_exc); // R3

    AST_LEN_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst)
        st.len_m1 <= st.maxlen_m1); // R5

    AST_OFFS_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
        (st.src_elem_off <= st.len_m1) && (st.dst_elem_off <= st.len_m1)); // R6

    AST_SUB_WITHIN_GRP: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> (step_sub <= st.grp_enc) && (step_elem <= st.len_m1)); // R7

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && stall) |=> ($stable(step_elem) && $stable(step_sub))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !step_valid); // R9

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && seq_busy) |=> ($stable(cfg_state) && !grp_exc)); // R11

endmodule

bind sv_group_loop sv_group_loop_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_grp    (cfg_grp),
    .cfg_state  (cfg_state),
    .grp_exc    (grp_exc),
    .stall      (stall),
    .step_valid (step_valid),
    .step_elem  (step_elem),
    .step_sub   (step_sub),
    .done       (done),
    .seq_busy   (seq_busy)
);

// File: tb/sv_group_loop_tb.sv
`timescale 1ns/1ps
module sv_group_loop_tb;
    import sv_grp_pkg::*;

    localparam int ITEM_W = IDX_W + SUB_W + 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wr = 1'b0;
    logic [LEN_W-1:0]   cfg_maxlen = '0;
    logic [LEN_W-1:0]   cfg_len = '0;
    logic [IDX_W-1:0]   cfg_src_off = '0;
    logic [IDX_W-1:0]   cfg_dst_off = '0;
    logic [GRP_W-1:0]   cfg_grp = '0;
    logic [SUB_W-1:0]   cfg_src_sub = '0;
    logic [SUB_W-1:0]   cfg_dst_sub = '0;
    logic [STATE_W-1:0] cfg_state;
    logic               grp_exc;
    logic               start = 1'b0;
    logic               stall = 1'b0;
    logic [XLEN-1:0]    pred_mask = '0;
    logic               step_valid;
    logic [IDX_W-1:0]   step_elem;
    logic [SUB_W-1:0]   step_sub;
    logic               step_en;
    logic               done;

    always #4 clk = ~clk;

    sv_group_loop u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_maxlen(cfg_maxlen),
        .cfg_len(cfg_len), .cfg_src_off(cfg_src_off), .cfg_dst_off(cfg_dst_off),
        .cfg_grp(cfg_grp), .cfg_src_sub(cfg_src_sub), .cfg_dst_sub(cfg_dst_sub),
        .cfg_state(cfg_state), .grp_exc(grp_exc), .start(start), .stall(stall),
        .pred_mask(pred_mask), .step_valid(step_valid), .step_elem(step_elem),
        .step_sub(step_sub), .step_en(step_en), .done(done)
    );

    int n_run = 0;
    int n_fail = 0;
    bit ended = 0;

    // Model of the stored configuration (plain values).
    int m_max = 1, m_len = 1, m_src = 0, m_dst = 0, m_grp = 1, m_ss = 0, m_ds = 0;

    logic [ITEM_W-1:0] exp_q[$];
    logic [ITEM_W-1:0] mon_exp;
    logic [ITEM_W-1:0] mon_got;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [STATE_W-1:0] exp_state();
        return {SUB_W'(m_ds), SUB_W'(m_ss), SUB_W'(m_grp - 1), IDX_W'(m_dst),
                IDX_W'(m_src), IDX_W'(m_len - 1), IDX_W'(m_max - 1)};
    endfunction

    function automatic int lim(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Monitor: every issued step is compared against the scoreboard queue (R7, R8).
    always @(negedge clk) begin
        if (!rst && !ended && step_valid) begin
            mon_got = {step_elem, step_sub, step_en};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 step with empty scoreboard", 64'(mon_got), 64'(0));
            end else begin
                mon_exp = exp_q.pop_front();
                chk(mon_got == mon_exp, "R7 R8 step elem/sub/enable",
                    64'(mon_got), 64'(mon_exp));
            end
        end
    end

    task automatic cfg_write(input int mx, input int ln, input int so, input int dof,
                             input int g, input int ss, input int ds, input string tag);
        bit ill;
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_maxlen = LEN_W'(mx); cfg_len = LEN_W'(ln);
        cfg_src_off = IDX_W'(so); cfg_dst_off = IDX_W'(dof); cfg_grp = GRP_W'(g);
        cfg_src_sub = SUB_W'(ss); cfg_dst_sub = SUB_W'(ds);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        ill = (g < 1) || (g > MAX_GRP);
        if (!ill) m_grp = g;
        m_max = lim(mx, 1, XLEN);
        m_len = lim(ln, 1, m_max);
        m_src = lim(so, 0, m_len - 1);
        m_dst = lim(dof, 0, m_len - 1);
        m_ss  = lim(ss, 0, m_grp - 1);
        m_ds  = lim(ds, 0, m_grp - 1);
        @(negedge clk);
        chk(cfg_state == exp_state(), tag, 64'(cfg_state), 64'(exp_state()));
        chk(grp_exc == ill, "R3 exception flag after write", 64'(grp_exc), 64'(ill));
        @(negedge clk);
        chk(grp_exc == 1'b0, "R3 exception flag one cycle", 64'(grp_exc), 64'(0));
    endtask

    task automatic run_loop(input logic [XLEN-1:0] mask, input bit disturb);
        bit seen;
        int w;
        for (int e = m_src; e < m_len; e++)
            for (int s = (e == m_src) ? m_ss : 0; s < m_grp; s++)
                exp_q.push_back({IDX_W'(e), SUB_W'(s), mask[e]});
        pred_mask = mask;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (disturb) begin
            @(posedge clk); #1;
            stall = 1'b1; start = 1'b1; cfg_wr = 1'b1;
            cfg_grp = '0; cfg_maxlen = LEN_W'(3); cfg_len = LEN_W'(2);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(step_valid == 1'b0, "R10 no step while stalled", 64'(step_valid), 64'(0));
                chk(grp_exc == 1'b0, "R11 no exception while busy", 64'(grp_exc), 64'(0));
            end
            @(posedge clk); #1;
            stall = 1'b0; start = 1'b0; cfg_wr = 1'b0;
        end
        seen = 0;
        w = 0;
        while (!seen && w < 400) begin
            @(negedge clk);
            if (done) seen = 1;
            w++;
        end
        chk(seen, "R9 done pulse seen", 64'(seen), 64'(1));
        chk(exp_q.size() == 0, "R7 all steps issued", 64'(exp_q.size()), 64'(0));
        chk(step_valid == 1'b0, "R9 no step with done", 64'(step_valid), 64'(0));
        exp_q.delete();
        @(negedge clk);
        chk(done == 1'b0, "R9 done lasts one cycle", 64'(done), 64'(0));
        chk(cfg_state == exp_state(), "R11 state kept across walk",
            64'(cfg_state), 64'(exp_state()));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cfg_state == '0, "R1 reset state", 64'(cfg_state), 64'(0));
        chk(!step_valid && !done && !grp_exc, "R1 reset outputs",
            64'({step_valid, done, grp_exc}), 64'(0));

        cfg_write(8, 5, 1, 2, 3, 2, 1, "R2 R4 R5 R6 legal write");
        run_loop(64'b10110, 1'b0);

        cfg_write(8, 5, 1, 2, 0, 3, 3, "R3 group 0 rejected");
        cfg_write(8, 5, 1, 2, 5, 1, 0, "R3 group 5 rejected");

        cfg_write(0, 9, 7, 7, 1, 3, 3, "R4 R5 R6 low clamps");
        cfg_write(100, 70, 63, 40, 4, 3, 1, "R4 R5 R6 high clamps");
        run_loop({16{4'b1001}}, 1'b0);

        cfg_write(16, 3, 0, 0, 4, 0, 0, "R2 group 4");
        run_loop(64'b101, 1'b1);

        cfg_write(1, 1, 0, 0, 1, 0, 0, "R2 group 1");
        run_loop(64'b1, 1'b0);
        run_loop(64'b0, 1'b0);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule